// File: doc/BRIEF.md
# Commit-Time Load Value Replay Checker

This block verifies speculative loads by comparing data values rather than by watching addresses. A load that ran ahead of commit, or whose result came from a value predictor (a guessed pointer, for instance), writes a record into an 8-entry table indexed by its load tag. The record holds the address the load used and the 32-bit value it consumed.

When that load reaches commit, the block re-reads the same address from the cache. It compares the returned word with the recorded one and reports either a clean result or a mis-speculation for that tag. Stores perform in order at commit and are not snooped. A replayed value that matches is accepted as legal, even if other cores wrote the location in between.

Only one replay read is in flight at a time. The commit port is held off until the outstanding read returns. A commit for a tag that has no record is flagged as an error and no cache read is issued for it.

Top module: `ld_replay_chk`

## Requirements
- R1: After reset the commit port is ready, no cache read is requested, and the ok, mismatch and error outputs are all low.
- R2: A commit accepted for a tag that has a valid record drives `rd_req_o` high in the same cycle, with `rd_addr_o` equal to the recorded address.
- R3: From an accepted replay until the cycle after its response, `cmt_ready_o` is low. At most one replay read is outstanding at any time.
- R4: When the response data equals the recorded 32-bit value, `res_ok_o` is high for exactly the one cycle after the response, and `res_tag_o` holds the committed tag.
- R5: When any of the 32 data bits differ, `res_mismatch_o` is high for exactly the one cycle after the response, and `res_tag_o` holds the committed tag.
- R6: A commit accepted for a tag with no valid record issues no read and leaves the port ready. `err_o` is high for one cycle on the next cycle, with `res_tag_o` holding that tag.
- R7: A replay consumes its record, so a second commit of the same tag without a new record is reported as R6 describes.
- R8: A second record for a tag that has not yet committed replaces the address and value held for that tag.
- R9: At most one of `res_ok_o`, `res_mismatch_o` and `err_o` is high in any cycle.
- R10: A commit presented while `cmt_ready_o` is low is ignored: it issues no read and leaves the record for its tag in place.
- R11: A record written for a tag in the same cycle that the tag's replay response clears it survives, and that tag's next commit replays against it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | Write a speculative load record |
| rec_tag_i | input | 3 | Load tag of the record |
| rec_addr_i | input | 32 | Address the load used |
| rec_data_i | input | 32 | Value the load consumed |
| cmt_valid_i | input | 1 | Load at commit requests verification |
| cmt_tag_i | input | 3 | Tag of the committing load |
| cmt_ready_o | output | 1 | Commit port can accept a request |
| rd_req_o | output | 1 | Replay read request to the cache |
| rd_addr_o | output | 32 | Replay read address |
| rd_rsp_valid_i | input | 1 | Replay read response valid |
| rd_rsp_data_i | input | 32 | Replay read response data |
| res_ok_o | output | 1 | Replayed value matched (one-cycle pulse) |
| res_mismatch_o | output | 1 | Mis-speculation detected (one-cycle pulse) |
| err_o | output | 1 | Commit without a valid record (one-cycle pulse) |
| res_tag_o | output | 3 | Tag that the current result refers to |

## Verification
Several rules are checked by assertions on every cycle. These are the single-outstanding-read rule, the commit back-pressure while a read is pending, the mutual exclusion of the three result flags, the one-cycle width of verdicts, the rule that a verdict only follows a response, and the rule that a commit without a read produces an error. Other behaviours depend on data and on the history of the table, so only the bench scenarios can show them. These include the correct replay address, a mismatch in the top or bottom bit, consumption of a record by its replay, overwriting a record before commit, a commit ignored while busy, and a record that survives a clear in the same cycle.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } lrc_state_e;
endpackage

// File: rtl/lrc_table.sv
module lrc_table #(
  parameter int TAG_W  = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_en_i,
  input  logic [TAG_W-1:0]  clr_tag_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              lk_hit_o,
  output logic [ADDR_W-1:0] lk_addr_o,
  input  logic [TAG_W-1:0]  cmp_tag_i,
  output logic [DATA_W-1:0] cmp_data_o
);
  localparam int DEPTH = 1 << TAG_W;

  logic [DEPTH-1:0]  vld_q;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic wr_sel, clr_sel;
    assign wr_sel  = wr_en_i  && (wr_tag_i  == TAG_W'(e));
    assign clr_sel = clr_en_i && (clr_tag_i == TAG_W'(e));

    // a new record beats a clear on the same entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e]  <= 1'b0;
        addr_q[e] <= '0;
        data_q[e] <= '0;
      end else if (wr_sel) begin
        vld_q[e]  <= 1'b1;
        addr_q[e] <= wr_addr_i;
        data_q[e] <= wr_data_i;
      end else if (clr_sel) begin
        vld_q[e]  <= 1'b0;
      end
    end
  end

  assign lk_hit_o   = vld_q[lk_tag_i];
  assign lk_addr_o  = addr_q[lk_tag_i];
  assign cmp_data_o = data_q[cmp_tag_i];
endmodule

// File: rtl/lrc_ctrl.sv
module lrc_ctrl
  import lrc_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmt_valid_i,
  input  logic [TAG_W-1:0] cmt_tag_i,
  input  logic             hit_i,
  input  logic             rsp_valid_i,
  output logic             ready_o,
  output logic             req_o,
  output logic             miss_o,
  output logic             fire_o,
  output logic [TAG_W-1:0] held_tag_o
);
  lrc_state_e      state_q, state_d;
  logic [TAG_W-1:0] held_q;
  logic             accept;

  always_comb begin
    ready_o = (state_q == ST_IDLE);
    accept  = cmt_valid_i && ready_o;
    req_o   = accept && hit_i;
    miss_o  = accept && !hit_i;
    fire_o  = (state_q == ST_WAIT) && rsp_valid_i;
    state_d = state_q;
    if (req_o)  state_d = ST_WAIT;
    if (fire_o) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      held_q  <= '0;
    end else begin
      state_q <= state_d;
      if (req_o) held_q <= cmt_tag_i;
    end
  end

  assign held_tag_o = held_q;
endmodule

// File: rtl/lrc_cmp.sv
module lrc_cmp #(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic [DATA_W-1:0] rec_data_i,
  input  logic [TAG_W-1:0]  held_tag_i,
  input  logic              miss_i,
  input  logic [TAG_W-1:0]  miss_tag_i,
  output logic              ok_o,
  output logic              mis_o,
  output logic              err_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic same;
  assign same = (rsp_data_i == rec_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_o  <= 1'b0;
      mis_o <= 1'b0;
      err_o <= 1'b0;
      tag_o <= '0;
    end else begin
      ok_o  <= fire_i && same;
      mis_o <= fire_i && !same;
      err_o <= miss_i && !fire_i;
      if (fire_i)      tag_o <= held_tag_i;
      else if (miss_i) tag_o <= miss_tag_i;
    end
  end
endmodule

// File: rtl/ld_replay_chk.sv
module ld_replay_chk #(
  parameter int TAG_W  = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_valid_i,
  input  logic [TAG_W-1:0]  rec_tag_i,
  input  logic [ADDR_W-1:0] rec_addr_i,
  input  logic [DATA_W-1:0] rec_data_i,
  input  logic              cmt_valid_i,
  input  logic [TAG_W-1:0]  cmt_tag_i,
  output logic              cmt_ready_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_rsp_valid_i,
  input  logic [DATA_W-1:0] rd_rsp_data_i,
  output logic              res_ok_o,
  output logic              res_mismatch_o,
  output logic              err_o,
  output logic [TAG_W-1:0]  res_tag_o
);
  logic              hit, miss, fire;
  logic [TAG_W-1:0]  held_tag;
  logic [DATA_W-1:0] rec_word;

  lrc_table #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (rec_valid_i),
    .wr_tag_i   (rec_tag_i),
    .wr_addr_i  (rec_addr_i),
    .wr_data_i  (rec_data_i),
    .clr_en_i   (fire),
    .clr_tag_i  (held_tag),
    .lk_tag_i   (cmt_tag_i),
    .lk_hit_o   (hit),
    .lk_addr_o  (rd_addr_o),
    .cmp_tag_i  (held_tag),
    .cmp_data_o (rec_word)
  );

  lrc_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmt_valid_i (cmt_valid_i),
    .cmt_tag_i   (cmt_tag_i),
    .hit_i       (hit),
    .rsp_valid_i (rd_rsp_valid_i),
    .ready_o     (cmt_ready_o),
    .req_o       (rd_req_o),
    .miss_o      (miss),
    .fire_o      (fire),
    .held_tag_o  (held_tag)
  );

  lrc_cmp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .rsp_data_i (rd_rsp_data_i),
    .rec_data_i (rec_word),
    .held_tag_i (held_tag),
    .miss_i     (miss),
    .miss_tag_i (cmt_tag_i),
    .ok_o       (res_ok_o),
    .mis_o      (res_mismatch_o),
    .err_o      (err_o),
    .tag_o      (res_tag_o)
  );
endmodule

// File: rtl/ld_replay_chk_sva.sv
module ld_replay_chk_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic cmt_valid_i,
  input logic cmt_ready_o,
  input logic rd_req_o,
  input logic rd_rsp_valid_i,
  input logic res_ok_o,
  input logic res_mismatch_o,
  input logic err_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pend_q <= 1'b0;
    else if (rd_req_o)       pend_q <= 1'b1;
    else if (rd_rsp_valid_i) pend_q <= 1'b0;
  end

  assert_single_outstanding_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !pend_q);

  assert_busy_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !cmt_ready_o);

  assert_rsp_frees_port_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && rd_rsp_valid_i) |=> cmt_ready_o);

  assert_verdict_after_rsp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_ok_o || res_mismatch_o) |-> $past(pend_q && rd_rsp_valid_i));

  assert_verdict_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_ok_o || res_mismatch_o) |=> !(res_ok_o || res_mismatch_o));

  assert_missing_record_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_valid_i && cmt_ready_o && !rd_req_o) |=> err_o);

  assert_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({res_ok_o, res_mismatch_o, err_o}) <= 1);
endmodule

bind ld_replay_chk ld_replay_chk_sva u_sva (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmt_valid_i    (cmt_valid_i),
  .cmt_ready_o    (cmt_ready_o),
  .rd_req_o       (rd_req_o),
  .rd_rsp_valid_i (rd_rsp_valid_i),
  .res_ok_o       (res_ok_o),
  .res_mismatch_o (res_mismatch_o),
  .err_o          (err_o)
);

// File: tb/sim_ld_replay_chk.sv
module sim_ld_replay_chk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0;
  logic [2:0]  rec_tag = '0;
  logic [31:0] rec_addr = '0, rec_data = '0;
  logic        cmt_valid = 1'b0;
  logic [2:0]  cmt_tag = '0;
  logic        cmt_ready, rd_req;
  logic [31:0] rd_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        res_ok, res_mis, err;
  logic [2:0]  res_tag;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ld_replay_chk u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rec_valid_i(rec_valid), .rec_tag_i(rec_tag), .rec_addr_i(rec_addr), .rec_data_i(rec_data),
    .cmt_valid_i(cmt_valid), .cmt_tag_i(cmt_tag), .cmt_ready_o(cmt_ready),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_rsp_valid_i(rsp_valid), .rd_rsp_data_i(rsp_data),
    .res_ok_o(res_ok), .res_mismatch_o(res_mis), .err_o(err), .res_tag_o(res_tag)
  );

  localparam int NV = 6;
  localparam logic [2:0]  V_TAG  [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
  localparam logic [31:0] V_ADDR [NV] = '{32'h1000, 32'h1004, 32'h1008, 32'h100C, 32'h1010, 32'h1014};
  localparam logic [31:0] V_REC  [NV] = '{32'h42, 32'hDEADBEEF, 32'h3C, 32'h80000000, 32'hFFFFFFFF, 32'h1};
  localparam logic [31:0] V_RSP  [NV] = '{32'h42, 32'hDEADBEEF, 32'h50, 32'h00000000, 32'hFFFFFFFF, 32'h0};

  task automatic chk(input bit cond, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic record(input logic [2:0] t, input logic [31:0] a, input logic [31:0] d);
    rec_valid = 1'b1; rec_tag = t; rec_addr = a; rec_data = d;
    tick();
    rec_valid = 1'b0;
  endtask

  task automatic replay(input logic [2:0] t, input logic [31:0] ea, input logic [31:0] rsp,
                        input bit exp_mis, input string rq);
    cmt_valid = 1'b1; cmt_tag = t; #1;
    chk(rd_req == 1'b1, "R2 req", 32'(rd_req), 32'd1);
    chk(rd_addr == ea, "R2 addr", rd_addr, ea);
    tick();
    cmt_valid = 1'b0; #1;
    chk(cmt_ready == 1'b0, "R3 busy", 32'(cmt_ready), 32'd0);
    chk(rd_req == 1'b0, "R3 single", 32'(rd_req), 32'd0);
    rsp_valid = 1'b1; rsp_data = rsp;
    tick();
    rsp_valid = 1'b0; #1;
    chk(res_ok == !exp_mis, {rq, " ok"}, 32'(res_ok), 32'(!exp_mis));
    chk(res_mis == exp_mis, {rq, " mismatch"}, 32'(res_mis), 32'(exp_mis));
    chk(res_tag == t, {rq, " tag"}, 32'(res_tag), 32'(t));
    chk(cmt_ready == 1'b1, "R3 free", 32'(cmt_ready), 32'd1);
    tick();
    chk(!res_ok && !res_mis, "R4 R5 pulse", {res_ok, res_mis}, 32'd0);
  endtask

  task automatic commit_miss(input logic [2:0] t, input string rq);
    cmt_valid = 1'b1; cmt_tag = t; #1;
    chk(rd_req == 1'b0, {rq, " no read"}, 32'(rd_req), 32'd0);
    tick();
    cmt_valid = 1'b0; #1;
    chk(err == 1'b1, {rq, " err"}, 32'(err), 32'd1);
    chk(res_tag == t, {rq, " tag"}, 32'(res_tag), 32'(t));
    chk(!res_ok && !res_mis, "R9 exclusive", {res_ok, res_mis}, 32'd0);
    chk(cmt_ready == 1'b1, {rq, " ready"}, 32'(cmt_ready), 32'd1);
    tick();
    chk(err == 1'b0, {rq, " pulse"}, 32'(err), 32'd0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2;
    // R1: state while reset is held
    chk(cmt_ready == 1'b1, "R1 ready", 32'(cmt_ready), 32'd1);
    chk({rd_req, res_ok, res_mis, err} == 4'b0, "R1 idle", 32'({rd_req, res_ok, res_mis, err}), 32'd0);
    #20; rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) record(V_TAG[i], V_ADDR[i], V_REC[i]);
    for (int i = 0; i < NV; i++)
      replay(V_TAG[i], V_ADDR[i], V_RSP[i], V_REC[i] != V_RSP[i],
             (V_REC[i] != V_RSP[i]) ? "R5" : "R4");

    // R6: no record ever written for tag 6
    commit_miss(3'd6, "R6");
    // R7: tag 0 consumed by its replay above
    commit_miss(3'd0, "R7");

    // R8: second record replaces the first
    record(3'd7, 32'h2000, 32'h11111111);
    record(3'd7, 32'h2040, 32'h22222222);
    replay(3'd7, 32'h2040, 32'h22222222, 1'b0, "R8");

    // R10: commit of tag 1 while tag 0 is pending is ignored
    record(3'd0, 32'h3000, 32'hA5A5A5A5);
    record(3'd1, 32'h3004, 32'h5A5A5A5A);
    cmt_valid = 1'b1; cmt_tag = 3'd0;
    tick();
    cmt_tag = 3'd1; #1;
    chk(rd_req == 1'b0, "R10 no read", 32'(rd_req), 32'd0);
    tick();
    cmt_valid = 1'b0;
    rsp_valid = 1'b1; rsp_data = 32'hA5A5A5A5;
    tick();
    rsp_valid = 1'b0; #1;
    chk(res_ok == 1'b1 && res_tag == 3'd0, "R10 first result", {res_ok, res_tag}, 32'h8);
    tick();
    replay(3'd1, 32'h3004, 32'h5A5A5A5A, 1'b0, "R10 kept");

    // R11: new record on the cycle the old one is cleared
    record(3'd2, 32'h4000, 32'h0000AAAA);
    cmt_valid = 1'b1; cmt_tag = 3'd2;
    tick();
    cmt_valid = 1'b0;
    rsp_valid = 1'b1; rsp_data = 32'h0000AAAA;
    rec_valid = 1'b1; rec_tag = 3'd2; rec_addr = 32'h4400; rec_data = 32'h0000BBBB;
    tick();
    rsp_valid = 1'b0; rec_valid = 1'b0; #1;
    chk(res_ok == 1'b1, "R11 first ok", 32'(res_ok), 32'd1);
    tick();
    replay(3'd2, 32'h4400, 32'h0000BBBC, 1'b1, "R11 survives");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule